// File: doc/BRIEF.md
# Byte-Addressed Register Slave on a Two-Wire Serial Bus

This block is a target device on a two-wire, open-drain serial bus of the kind used between chips on a board. It answers at a single 7-bit device address, set by a parameter, and holds a bank of 256 byte-wide registers. The two bus lines are oversampled on the system clock. The block pulls the data line low through an output-enable pin and never drives it high.

A write access carries a one-byte register index first. That index loads an internal pointer. Every byte after it is stored at the pointer, and the pointer then steps forward by one. A read access sends the register at the pointer and steps the pointer forward. It keeps sending while the bus master acknowledges each byte. The pointer survives a repeated start, so the usual sequence works: set the index with a write, issue a repeated start, then read from that index.

Local logic on the chip can look up any register directly through a side read port. It also sees a one-cycle strobe, with the register index and the data, each time the bus writes a register.

Top module: `i2c_regfile_slave`

## Requirements
- R1: A falling data line while the clock line is high (start) abandons any byte in progress and begins a new address byte. A rising data line while the clock line is high (stop) returns the block to idle with the data line released. Neither event touches the registers or the pointer.
- R2: Bits arrive while the clock line is high, most significant bit first, eight per byte. When bits 7..1 of the first byte after a start equal the device address, the block pulls the data line low during the ninth clock. Bit 0 selects the direction: 0 for write, 1 for read.
- R3: When the address does not match, the block never pulls the data line low and stores nothing until the next start.
- R4: In a write access, the first byte after the address byte loads the register pointer.
- R5: Each later byte of a write access is stored in the register at the pointer, and the pointer then increments. Each store raises the write strobe for exactly one cycle, together with that index and data.
- R6: Every byte received in an addressed write access is acknowledged by pulling the data line low during its ninth clock.
- R7: A repeated start after the index byte keeps the pointer, so a following read access returns data starting at that index.
- R8: In a read access the block shifts out the register at the pointer, most significant bit first, and increments the pointer. It sends the next byte only if the master pulled the data line low on the ninth clock. After a master not-acknowledge it releases the data line until the next start.
- R9: The pointer wraps from 255 to 0.
- R10: A write access that carries only the index byte and then a stop changes the pointer but stores no register and raises no strobe.
- R11: The data-line enable changes only after a falling edge of the clock line has been seen, and never while the clock line stays high.
- R12: After reset the data line is released, the strobe is low and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| loc_addr_i | input | 8 | Register index for the side read port |
| loc_data_o | output | 8 | Contents of the register at loc_addr_i |
| wr_stb_o | output | 1 | One-cycle pulse for each register stored from the bus |
| wr_addr_o | output | 8 | Index of the stored register |
| wr_data_o | output | 8 | Byte stored |

## Verification
Single-byte writes, each read back through a repeated start, are run from a table of index/data pairs. The pairs cover the all-zero and all-one bytes, alternating bit patterns and indices at both ends of the range, so they show up a swapped bit order or a lost index bit. Four-byte bursts in each direction separate a pointer that increments from one that holds still. The burst read also checks that the line stays released after the master's not-acknowledge. A burst across index 255 exposes a pointer that does not wrap. Two further cases test what must not change anything: an address one bit off, followed by data, and a write that carries only the index byte. A start in the middle of a byte shows whether the bit counter is cleared.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int DEV_W  = 7;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = 8;
    localparam int CNT_W  = $clog2(BYTE_W) + 1;

    typedef enum logic [2:0] {
        L_IDLE,
        L_ADDR,
        L_AACK,
        L_RX,
        L_WACK,
        L_TX,
        L_MACK,
        L_SKIP
    } lstate_e;

    typedef struct packed {
        lstate_e             state;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   shreg;
        logic [IDX_W-1:0]    ptr;
        logic                idx_pend;
        logic                rnw;
        logic                m_nack;
        logic                oe;
        logic                wstb;
        logic [IDX_W-1:0]    waddr;
        logic [BYTE_W-1:0]   wdata;
    } link_s;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);
    localparam int PIPE_W = STAGES + 1;

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [PIPE_W-1:0] pipe_d, pipe_q;

        always_comb begin
            pipe_d = {pipe_q[PIPE_W-2:0], async_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= pipe_d;
        end

        assign sync_o[g] = pipe_q[STAGES-1];
        assign prev_o[g] = pipe_q[STAGES];
    end

endmodule

// File: rtl/i2cs_regbank.sv
module i2cs_regbank #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_a_i,
    output logic [DW-1:0] rdata_a_o,
    input  logic [AW-1:0] raddr_b_i,
    output logic [DW-1:0] rdata_b_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we_i) mem_d[waddr_i] = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_a_o = mem_q[raddr_a_i];
    assign rdata_b_o = mem_q[raddr_b_i];

    // R5: a bus store lands in the bank on the next cycle
    assert_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));

endmodule

// File: rtl/i2cs_link.sv
module i2cs_link
    import i2cs_pkg::*;
#(
    parameter logic [DEV_W-1:0] OWN_ADDR = 7'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s_i,
    input  logic              scl_p_i,
    input  logic              sda_s_i,
    input  logic              sda_p_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [IDX_W-1:0]  ptr_o,
    output logic              sda_oe_o,
    output logic              wr_stb_o,
    output logic [IDX_W-1:0]  wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);
    localparam logic [IDX_W-1:0] ONE  = IDX_W'(1);

    link_s q, d;

    logic scl_rise, scl_fall, start_evt, stop_evt;

    assign scl_rise  =  scl_s_i & ~scl_p_i;
    assign scl_fall  = ~scl_s_i &  scl_p_i;
    assign start_evt =  scl_s_i &  scl_p_i &  sda_p_i & ~sda_s_i;
    assign stop_evt  =  scl_s_i &  scl_p_i & ~sda_p_i &  sda_s_i;

    always_comb begin
        d      = q;
        d.wstb = 1'b0;
        if (start_evt) begin
            d.state = L_ADDR;
            d.cnt   = '0;
            d.oe    = 1'b0;
        end else if (stop_evt) begin
            d.state = L_IDLE;
            d.oe    = 1'b0;
        end else begin
            unique case (q.state)
                L_ADDR: begin
                    if (scl_rise && q.cnt < FULL) begin
                        d.shreg = {q.shreg[BYTE_W-2:0], sda_s_i};
                        d.cnt   = q.cnt + 1'b1;
                    end
                    if (scl_fall && q.cnt == FULL) begin
                        if (q.shreg[BYTE_W-1:1] == OWN_ADDR) begin
                            d.state = L_AACK;
                            d.oe    = 1'b1;
                            d.rnw   = q.shreg[0];
                        end else begin
                            d.state = L_SKIP;
                            d.oe    = 1'b0;
                        end
                    end
                end
                L_AACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rnw) begin
                            d.state = L_TX;
                            d.shreg = rd_data_i;
                            d.oe    = ~rd_data_i[BYTE_W-1];
                            d.ptr   = q.ptr + ONE;
                        end else begin
                            d.state    = L_RX;
                            d.oe       = 1'b0;
                            d.idx_pend = 1'b1;
                        end
                    end
                end
                L_RX: begin
                    if (scl_rise && q.cnt < FULL) begin
                        d.shreg = {q.shreg[BYTE_W-2:0], sda_s_i};
                        d.cnt   = q.cnt + 1'b1;
                    end
                    if (scl_fall && q.cnt == FULL) begin
                        if (q.idx_pend) begin
                            d.ptr      = q.shreg;
                            d.idx_pend = 1'b0;
                        end else begin
                            d.wstb  = 1'b1;
                            d.waddr = q.ptr;
                            d.wdata = q.shreg;
                            d.ptr   = q.ptr + ONE;
                        end
                        d.oe    = 1'b1;
                        d.state = L_WACK;
                    end
                end
                L_WACK: begin
                    if (scl_fall) begin
                        d.oe    = 1'b0;
                        d.cnt   = '0;
                        d.state = L_RX;
                    end
                end
                L_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == LAST) begin
                            d.oe    = 1'b0;
                            d.cnt   = '0;
                            d.state = L_MACK;
                        end else begin
                            d.cnt   = q.cnt + 1'b1;
                            d.shreg = {q.shreg[BYTE_W-2:0], 1'b0};
                            d.oe    = ~q.shreg[BYTE_W-2];
                        end
                    end
                end
                L_MACK: begin
                    if (scl_rise) d.m_nack = sda_s_i;
                    if (scl_fall) begin
                        if (!q.m_nack) begin
                            d.state = L_TX;
                            d.shreg = rd_data_i;
                            d.oe    = ~rd_data_i[BYTE_W-1];
                            d.ptr   = q.ptr + ONE;
                            d.cnt   = '0;
                        end else begin
                            d.state = L_SKIP;
                            d.oe    = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= L_IDLE;
        end else begin
            q <= d;
        end
    end

    assign ptr_o     = q.ptr;
    assign sda_oe_o  = q.oe;
    assign wr_stb_o  = q.wstb;
    assign wr_addr_o = q.waddr;
    assign wr_data_o = q.wdata;

    // R11: the enable moves only after a seen clock fall (or a bus reset event)
    assert_oe_after_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.oe != $past(q.oe)) |-> ($past(scl_fall) || $past(start_evt) || $past(stop_evt)));

    // R3: a non-matching access never drives the line
    assert_skip_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == L_SKIP) |-> !q.oe);

    // R1: a start re-arms the address byte
    assert_start_rearm_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_evt) |-> (q.state == L_ADDR && q.cnt == '0 && !q.oe));

    // R5: the store strobe lasts one cycle
    assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.wstb |=> !q.wstb);

    // R9: storing at the top index wraps the pointer
    assert_ptr_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wstb && q.waddr == '1) |-> (q.ptr == '0));

    // R10: the index byte never raises a store
    assert_index_no_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.state) == L_RX && $past(q.idx_pend) && q.state == L_WACK) |-> !q.wstb);

    // R8: after a master not-acknowledge the line is released
    assert_nack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.state) == L_MACK && $past(q.m_nack) && q.state == L_SKIP) |-> !q.oe);

endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
    import i2cs_pkg::*;
#(
    parameter logic [DEV_W-1:0] OWN_ADDR    = 7'h2A,
    parameter int               SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [IDX_W-1:0]  loc_addr_i,
    output logic [BYTE_W-1:0] loc_data_o,
    output logic              wr_stb_o,
    output logic [IDX_W-1:0]  wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o
);
    localparam int LINES = 2;
    localparam int SCL_B = 0;
    localparam int SDA_B = 1;

    logic [LINES-1:0]  line_s, line_p;
    logic [IDX_W-1:0]  ptr;
    logic [BYTE_W-1:0] tx_byte;

    i2cs_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sda_i, scl_i}),
        .sync_o  (line_s),
        .prev_o  (line_p)
    );

    i2cs_link #(.OWN_ADDR(OWN_ADDR)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s_i   (line_s[SCL_B]),
        .scl_p_i   (line_p[SCL_B]),
        .sda_s_i   (line_s[SDA_B]),
        .sda_p_i   (line_p[SDA_B]),
        .rd_data_i (tx_byte),
        .ptr_o     (ptr),
        .sda_oe_o  (sda_oe_o),
        .wr_stb_o  (wr_stb_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o)
    );

    i2cs_regbank #(.AW(IDX_W), .DW(BYTE_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (wr_stb_o),
        .waddr_i   (wr_addr_o),
        .wdata_i   (wr_data_o),
        .raddr_a_i (ptr),
        .rdata_a_o (tx_byte),
        .raddr_b_i (loc_addr_i),
        .rdata_b_o (loc_data_o)
    );

endmodule

// File: tb/sim_i2c_regfile_slave.sv
module sim_i2c_regfile_slave;

    localparam int Q = 10;
    localparam logic [6:0] DEV = 7'h2A;
    localparam logic [7:0] AW = {DEV, 1'b0};
    localparam logic [7:0] AR = {DEV, 1'b1};
    localparam int NV = 6;
    localparam logic [15:0] VEC [NV] = '{16'h00A5, 16'h7F3C, 16'h80FF,
                                         16'h0100, 16'hFE5A, 16'h33C3};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe_o;
    logic sda_line;
    logic [7:0] loc_addr = 8'h00;
    logic [7:0] loc_data_o;
    logic wr_stb_o;
    logic [7:0] wr_addr_o, wr_data_o;

    int total = 0;
    int bad = 0;
    int stb_cnt = 0;
    logic [7:0] stb_addr = 8'h00, stb_data = 8'h00;
    int oe_seen = 0;
    logic watch = 1'b0;
    int r11_viol = 0;
    logic scl_prev = 1'b1, oe_prev = 1'b0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe_o;

    i2c_regfile_slave #(.OWN_ADDR(DEV)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe_o), .loc_addr_i(loc_addr), .loc_data_o(loc_data_o),
        .wr_stb_o(wr_stb_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
    );

    always @(posedge clk) begin
        if (wr_stb_o) begin
            stb_cnt++;
            stb_addr = wr_addr_o;
            stb_data = wr_data_o;
        end
        if (watch && sda_oe_o) oe_seen++;
        if (rst_n && scl && scl_prev && sda_oe_o != oe_prev) r11_viol++;
        scl_prev = scl;
        oe_prev  = sda_oe_o;
    end

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); b = sda_line; wq(); scl = 1'b0; wq();
    endtask

    task automatic wr_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(b);
        acked = ~b;
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        bit_out(~give_ack);
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] v);
        loc_addr = a;
        @(negedge clk);
        v = loc_data_o;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] v;
        logic [7:0] rb [4];
        int s0;

        repeat (5) @(negedge clk);
        // R12: reset state
        chk(sda_oe_o == 1'b0, "R12 oe after reset", sda_oe_o, 0);
        chk(wr_stb_o == 1'b0, "R12 strobe after reset", wr_stb_o, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        peek(8'h10, v);
        chk(v == 8'h00, "R12 register after reset", v, 0);

        // Table: single write, then index-set / repeated start / read back
        for (int k = 0; k < NV; k++) begin
            logic [7:0] idx, dat;
            idx = VEC[k][15:8];
            dat = VEC[k][7:0];
            m_start();
            wr_byte(AW, ack);
            chk(ack, "R2 address ack", ack, 1);
            wr_byte(idx, ack);
            chk(ack, "R4 index ack", ack, 1);
            wr_byte(dat, ack);
            chk(ack, "R6 data ack", ack, 1);
            m_stop();
            chk(stb_addr == idx && stb_data == dat, "R5 strobe addr/data",
                {stb_addr, stb_data}, {idx, dat});
            peek(idx, v);
            chk(v == dat, "R5 stored value", v, dat);
            m_start();
            wr_byte(AW, ack);
            wr_byte(idx, ack);
            m_start();
            wr_byte(AR, ack);
            chk(ack, "R2 read address ack", ack, 1);
            rd_byte(1'b0, v);
            m_stop();
            chk(v == dat, "R7 read after repeated start", v, dat);
        end

        // Burst write of four bytes from index 0x40
        s0 = stb_cnt;
        m_start();
        wr_byte(AW, ack);
        wr_byte(8'h40, ack);
        for (int i = 0; i < 4; i++) begin
            wr_byte(8'h11 * (i + 1), ack);
            chk(ack, "R6 burst ack", ack, 1);
        end
        m_stop();
        chk(stb_cnt == s0 + 4, "R5 burst strobe count", stb_cnt, s0 + 4);
        for (int i = 0; i < 4; i++) begin
            peek(8'h40 + 8'(i), v);
            chk(v == 8'(8'h11 * (i + 1)), "R5 burst increment", v, 8'h11 * (i + 1));
        end

        // Burst read with master acks, then not-acknowledge
        m_start();
        wr_byte(AW, ack);
        wr_byte(8'h40, ack);
        m_start();
        wr_byte(AR, ack);
        for (int i = 0; i < 4; i++) rd_byte(i != 3, rb[i]);
        for (int i = 0; i < 4; i++)
            chk(rb[i] == 8'(8'h11 * (i + 1)), "R8 burst read", rb[i], 8'h11 * (i + 1));
        rd_byte(1'b0, v);
        chk(v == 8'hFF, "R8 line released after nack", v, 8'hFF);
        m_stop();

        // Pointer wrap
        m_start();
        wr_byte(AW, ack);
        wr_byte(8'hFF, ack);
        wr_byte(8'h77, ack);
        wr_byte(8'h88, ack);
        m_stop();
        peek(8'hFF, v);
        chk(v == 8'h77, "R9 top register", v, 8'h77);
        peek(8'h00, v);
        chk(v == 8'h88, "R9 wrapped to index 0", v, 8'h88);

        // Non-matching addresses: one low bit off, one top bit off
        s0 = stb_cnt;
        oe_seen = 0;
        watch = 1'b1;
        m_start();
        wr_byte({7'h2B, 1'b0}, ack);
        chk(!ack, "R3 no ack for other address", ack, 0);
        wr_byte(8'h10, ack);
        wr_byte(8'h99, ack);
        m_stop();
        m_start();
        wr_byte({7'h6A, 1'b1}, ack);
        chk(!ack, "R3 no ack for top-bit address", ack, 0);
        rd_byte(1'b1, v);
        m_stop();
        watch = 1'b0;
        chk(oe_seen == 0, "R3 line never driven", oe_seen, 0);
        chk(stb_cnt == s0, "R3 no store", stb_cnt, s0);
        peek(8'h10, v);
        chk(v == 8'h00, "R3 register untouched", v, 0);

        // Index-only write, then read without an index
        s0 = stb_cnt;
        m_start();
        wr_byte(AW, ack);
        wr_byte(8'h41, ack);
        m_stop();
        chk(stb_cnt == s0, "R10 no strobe on index-only write", stb_cnt, s0);
        peek(8'h41, v);
        chk(v == 8'h22, "R10 register unchanged", v, 8'h22);
        m_start();
        wr_byte(AR, ack);
        rd_byte(1'b1, rb[0]);
        rd_byte(1'b0, rb[1]);
        m_stop();
        chk(rb[0] == 8'h22 && rb[1] == 8'h33, "R10 pointer moved",
            {rb[0], rb[1]}, 16'h2233);

        // Start in the middle of a byte
        m_start();
        wr_byte(AW, ack);
        wr_byte(8'h50, ack);
        bit_out(1'b1);
        bit_out(1'b0);
        bit_out(1'b1);
        m_start();
        wr_byte(AW, ack);
        chk(ack, "R1 address ack after mid-byte start", ack, 1);
        wr_byte(8'h60, ack);
        wr_byte(8'h9E, ack);
        m_stop();
        peek(8'h50, v);
        chk(v == 8'h00, "R1 partial byte discarded", v, 0);
        peek(8'h60, v);
        chk(v == 8'h9E, "R1 new access stored", v, 8'h9E);
        chk(sda_oe_o == 1'b0, "R1 released after stop", sda_oe_o, 0);

        chk(r11_viol == 0, "R11 enable steady while clock high", r11_viol, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule